// File: doc/BRIEF.md
# Dual DAC Command and Register Controller

This block holds the digital state behind a two-channel digital-to-analog converter. A serial front end that is not part of this block delivers 24-bit command words, each with a one-cycle valid strobe. The block decodes each word and updates two register stages per channel. The first stage is a staging (input) register. The second is the active (DAC) register, whose code drives the converter. Each channel also has a power-down flag. A level-sensitive load pin copies both staging registers into the active registers at once. The pin is ignored while the front end reports that a word is still being shifted in.

Waking a powered-down channel starts a settling timer for that channel. The settled flag stays low until the timer expires. The wait is short when the other channel is running. It is long when the other channel was also asleep, because the shared bias must restart first. The delays are parameters counted in clock cycles.

The converter resolution is a parameter. The 16-bit data field is left-justified, so a narrower channel takes the upper bits and drops the low ones. A second parameter chooses whether the registers come out of reset at zero scale or at midscale.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset both active codes and both staging registers hold zero scale (midscale, that is only the MSB set, when RESET_MID is 1). Both channels are powered up (`pd_o` = 00) and settled (`settled_o` = 11).
- R2: A word is sampled on a clock edge where `word_valid_i` is high. Its operation code is bits 23:20, its channel select is bits 19:16 and its data is bits 15:0. The code a channel stores is data bits 15 down to 16-RES_BITS. All outputs are registered and change after the sampling edge.
- R3: Operation 0000 loads the data into the selected staging registers and leaves the active codes and power state unchanged.
- R4: Operation 0001 copies the selected staging registers into the active registers and powers those channels up.
- R5: Operation 0011 loads the data into both register stages of the selected channels and powers them up. The new code appears at the output after the sampling edge.
- R6: Operation 0100 powers the selected channels down. It ignores the data field and changes neither register stage, so the active code output keeps its value.
- R7: Operation 1111 does nothing. Operation codes other than 0000, 0001, 0011, 0100 and 1111 are ignored, and so are channel selects other than 0000, 0001 and 1111.
- R8: Channel select 0000 addresses channel A (index 0), 0001 addresses channel B (index 1), and 1111 addresses both.
- R9: On an edge where `load_i` is high, `rx_busy_i` is low and no word is valid, both staging registers are copied into the active registers and both channels power up. With `rx_busy_i` high, or in a cycle that carries a valid word, the pin has no effect.
- R10: When an update wakes a powered-down channel, its settled flag rises WAKE_SHORT_CYC cycles after `pd_o` falls if the other channel was powered up on the waking edge. It rises WAKE_LONG_CYC cycles after if the other channel was powered down, and this includes both channels woken on the same edge.
- R11: The settled flag is low while its channel is powered down. An update of a channel that is already powered up does not change its settled flag or restart its timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 24 | Command word: operation, channel select, data |
| word_valid_i | input | 1 | One-cycle strobe that marks `word_i` valid |
| load_i | input | 1 | Load pin, updates both channels while high |
| rx_busy_i | input | 1 | High while a word is being shifted in; blocks the load pin |
| code_a_o | output | RES_BITS | Active code of channel A |
| code_b_o | output | RES_BITS | Active code of channel B |
| pd_o | output | 2 | Power-down flag per channel (bit 0 = A) |
| settled_o | output | 2 | Settled flag per channel (bit 0 = A) |

## Verification
The assertions watch several properties on every cycle. A power-down request leaves both register stages untouched. Any update leaves the channel powered up. A no-op word or a busy front end leaves the codes and power flags steady. A channel never reports settled on the edge it wakes, and the timer never counts past the long delay. The exact settling length only shows up in the bench's scenarios, and so does which length applies, since that depends on the other channel. The same holds for the old-versus-new data that the two update forms deliver and for the rejection of reserved codes. The bench compares each of these against its own model, cycle by cycle.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

    localparam int DATA_W = 16;
    localparam int WORD_W = 24;
    localparam int NCH    = 2;

    typedef enum logic [3:0] {
        OP_STAGE  = 4'h0,
        OP_COMMIT = 4'h1,
        OP_BOTH   = 4'h3,
        OP_SLEEP  = 4'h4,
        OP_IDLE   = 4'hF
    } op_e;

    localparam logic [3:0] SEL_A   = 4'h0;
    localparam logic [3:0] SEL_B   = 4'h1;
    localparam logic [3:0] SEL_ALL = 4'hF;

    // per-channel action decoded from one cycle of input
    typedef struct packed {
        logic stage;     // load staging register from data
        logic commit;    // copy into active register, power up
        logic use_new;   // active register takes the word data, not staging
        logic sleep;     // power down
    } chan_act_t;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dual_dac_pkg::*;
(
    input  logic [WORD_W-1:0]         word_i,
    input  logic                      word_valid_i,
    input  logic                      load_i,
    input  logic                      rx_busy_i,
    output chan_act_t [NCH-1:0]       act_o
);

    logic [3:0]     op;
    logic [3:0]     sel;
    logic [NCH-1:0] hit;
    logic           pin_go;

    always_comb begin
        op     = word_i[23:20];
        sel    = word_i[19:16];
        hit[0] = (sel == SEL_A) || (sel == SEL_ALL);
        hit[1] = (sel == SEL_B) || (sel == SEL_ALL);
        pin_go = load_i && !rx_busy_i;
        act_o  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (word_valid_i) begin
                if (hit[c]) begin
                    case (op)
                        OP_STAGE:  act_o[c].stage = 1'b1;
                        OP_COMMIT: act_o[c].commit = 1'b1;
                        OP_BOTH: begin
                            act_o[c].stage   = 1'b1;
                            act_o[c].commit  = 1'b1;
                            act_o[c].use_new = 1'b1;
                        end
                        OP_SLEEP:  act_o[c].sleep = 1'b1;
                        default:   act_o[c] = '0;
                    endcase
                end
            end else if (pin_go) begin
                act_o[c].commit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
    import dual_dac_pkg::*;
#(
    parameter int RES_BITS  = 16,
    parameter bit RESET_MID = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  chan_act_t           act_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic [RES_BITS-1:0] code_o,
    output logic                pd_o,
    output logic                wake_o
);

    localparam logic [RES_BITS-1:0] RST_CODE =
        RESET_MID ? {1'b1, {(RES_BITS-1){1'b0}}} : '0;

    typedef struct packed {
        logic [RES_BITS-1:0] stg;
        logic [RES_BITS-1:0] act;
        logic                pd;
    } regs_t;

    regs_t               s_d, s_q;
    logic [RES_BITS-1:0] data_cut;

    always_comb begin
        data_cut = data_i[DATA_W-1 -: RES_BITS];
        s_d      = s_q;
        wake_o   = act_i.commit && s_q.pd;
        if (act_i.commit) begin
            s_d.act = act_i.use_new ? data_cut : s_q.stg;
            s_d.pd  = 1'b0;
        end
        if (act_i.stage) begin
            s_d.stg = data_cut;
        end
        if (act_i.sleep) begin
            s_d.pd = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.stg <= RST_CODE;
            s_q.act <= RST_CODE;
            s_q.pd  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.act;
    assign pd_o   = s_q.pd;

    // R6: sleeping never disturbs either register stage
    p_sleep_keeps_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_i.sleep |=> ($stable(s_q.act) && $stable(s_q.stg) && s_q.pd));

    // R4: any update leaves the channel running
    p_commit_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_i.commit |=> !s_q.pd);

endmodule

// File: rtl/dac_wake_timer.sv
module dac_wake_timer #(
    parameter int SHORT_CYC = 1000,
    parameter int LONG_CYC  = 2400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic long_i,
    input  logic sleep_i,
    input  logic pd_i,
    output logic settled_o
);

    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (sleep_i) begin
            t_d.cnt = '0;
        end else if (wake_i) begin
            t_d.cnt = long_i ? LONG_LD : SHORT_LD;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.cnt <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign settled_o = !pd_i && (t_q.cnt == '0);

    // R10: a freshly woken channel is never reported settled at once
    p_no_instant_settle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_i) |-> !settled_o);

    // R10: the counter stays within the long delay
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= LONG_LD);

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
    import dual_dac_pkg::*;
#(
    parameter int RES_BITS       = 16,
    parameter bit RESET_MID      = 1'b0,
    parameter int WAKE_SHORT_CYC = 1000,
    parameter int WAKE_LONG_CYC  = 2400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [23:0]         word_i,
    input  logic                word_valid_i,
    input  logic                load_i,
    input  logic                rx_busy_i,
    output logic [RES_BITS-1:0] code_a_o,
    output logic [RES_BITS-1:0] code_b_o,
    output logic [1:0]          pd_o,
    output logic [1:0]          settled_o
);

    chan_act_t [NCH-1:0]               act;
    logic [NCH-1:0]                    pd;
    logic [NCH-1:0]                    wake;
    logic [NCH-1:0]                    settled;
    logic [NCH-1:0][RES_BITS-1:0]      code;

    dac_cmd_decode u_dec (
        .word_i       (word_i),
        .word_valid_i (word_valid_i),
        .load_i       (load_i),
        .rx_busy_i    (rx_busy_i),
        .act_o        (act)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dac_chan_regs #(
            .RES_BITS  (RES_BITS),
            .RESET_MID (RESET_MID)
        ) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .act_i  (act[c]),
            .data_i (word_i[DATA_W-1:0]),
            .code_o (code[c]),
            .pd_o   (pd[c]),
            .wake_o (wake[c])
        );

        dac_wake_timer #(
            .SHORT_CYC (WAKE_SHORT_CYC),
            .LONG_CYC  (WAKE_LONG_CYC)
        ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .wake_i    (wake[c]),
            .long_i    (pd[NCH-1-c]),
            .sleep_i   (act[c].sleep),
            .pd_i      (pd[c]),
            .settled_o (settled[c])
        );
    end

    assign code_a_o  = code[0];
    assign code_b_o  = code[1];
    assign pd_o      = pd;
    assign settled_o = settled;

    // R9: with the front end busy and no word, nothing visible moves
    p_busy_blocks_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy_i && !word_valid_i) |=>
            ($stable(code_a_o) && $stable(code_b_o) && $stable(pd_o)));

    // R7: an idle word changes no code and no power flag
    p_idle_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && word_i[23:20] == 4'hF) |=>
            ($stable(code_a_o) && $stable(code_b_o) && $stable(pd_o)));

    // R11: a powered-down channel never reports settled
    p_down_not_settled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_o[0]) |-> !settled_o[0]);

endmodule

// File: tb/dual_dac_ctrl_tb.sv
module dual_dac_ctrl_tb;

    localparam int RES   = 16;
    localparam int SHORT = 5;
    localparam int LONG  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [23:0]     word_i = '0;
    logic            word_valid_i = 1'b0;
    logic            load_i = 1'b0;
    logic            rx_busy_i = 1'b0;
    logic [RES-1:0]  code_a_o, code_b_o;
    logic [1:0]      pd_o, settled_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] m_stg [2];
    logic [15:0] m_act [2];
    logic [1:0]  m_pd;
    int          m_left [2];

    always #2.5 clk = ~clk;

    dual_dac_ctrl #(
        .RES_BITS       (RES),
        .RESET_MID      (1'b0),
        .WAKE_SHORT_CYC (SHORT),
        .WAKE_LONG_CYC  (LONG)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_i       (word_i),
        .word_valid_i (word_valid_i),
        .load_i       (load_i),
        .rx_busy_i    (rx_busy_i),
        .code_a_o     (code_a_o),
        .code_b_o     (code_b_o),
        .pd_o         (pd_o),
        .settled_o    (settled_o)
    );

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_stg[c]  = '0;
            m_act[c]  = '0;
            m_left[c] = 0;
        end
        m_pd = 2'b00;
    endtask

    // expected effect of one sampling edge, from the requirements
    task automatic model_step(input logic v, input logic [23:0] w,
                              input logic ld, input logic bz);
        logic [3:0] op;
        logic [3:0] sel;
        logic [1:0] hit, st, up, nw, sl, pd_prev;
        op  = w[23:20];
        sel = w[19:16];
        hit[0] = (sel == 4'h0) || (sel == 4'hF);
        hit[1] = (sel == 4'h1) || (sel == 4'hF);
        st = '0; up = '0; nw = '0; sl = '0;
        if (v) begin
            for (int c = 0; c < 2; c++) begin
                if (hit[c]) begin
                    case (op)
                        4'h0: st[c] = 1'b1;
                        4'h1: up[c] = 1'b1;
                        4'h3: begin st[c] = 1'b1; up[c] = 1'b1; nw[c] = 1'b1; end
                        4'h4: sl[c] = 1'b1;
                        default: ;
                    endcase
                end
            end
        end else if (ld && !bz) begin
            up = 2'b11;
        end
        pd_prev = m_pd;
        for (int c = 0; c < 2; c++) begin
            if (m_left[c] != 0) m_left[c]--;
            if (up[c]) m_act[c] = nw[c] ? w[15:0] : m_stg[c];
            if (st[c]) m_stg[c] = w[15:0];
            if (up[c]) begin
                m_pd[c] = 1'b0;
                if (pd_prev[c]) m_left[c] = pd_prev[1-c] ? LONG : SHORT;
            end
            if (sl[c]) begin
                m_pd[c]   = 1'b1;
                m_left[c] = 0;
            end
        end
    endtask

    task automatic check(input string tag);
        logic [RES-1:0] ea, eb;
        logic [1:0]     es;
        ea = m_act[0][15 -: RES];
        eb = m_act[1][15 -: RES];
        es[0] = !m_pd[0] && (m_left[0] == 0);
        es[1] = !m_pd[1] && (m_left[1] == 0);
        n_checks++;
        if (code_a_o !== ea || code_b_o !== eb || pd_o !== m_pd || settled_o !== es) begin
            n_fail++;
            $display("FAIL %s: got a=%h b=%h pd=%b st=%b, expected a=%h b=%h pd=%b st=%b",
                     tag, code_a_o, code_b_o, pd_o, settled_o, ea, eb, m_pd, es);
        end
    endtask

    // drive after a falling edge, sample at the next falling edge
    task automatic step(input logic v, input logic [23:0] w, input logic ld,
                        input logic bz, input string tag);
        word_valid_i = v;
        word_i       = w;
        load_i       = ld;
        rx_busy_i    = bz;
        @(posedge clk);
        model_step(v, w, ld, bz);
        @(negedge clk);
        check(tag);
    endtask

    task automatic send(input logic [3:0] op, input logic [3:0] sel,
                        input logic [15:0] d, input string tag);
        step(1'b1, {op, sel, d}, 1'b0, 1'b0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 24'h0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no end of test, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] ops [7];
        logic [3:0] sels [4];
        ops  = '{4'h0, 4'h1, 4'h3, 4'h4, 4'hF, 4'h2, 4'h7};
        sels = '{4'h0, 4'h1, 4'hF, 4'h3};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");

        // R3: staging write is invisible at the output
        send(4'h0, 4'h0, 16'h1234, "R3 stage A");
        // R4: commit staged value, channel was running so settled stays high (R11)
        send(4'h1, 4'h0, 16'hFFFF, "R4 commit A");
        check("R11 running update keeps settled");
        // R5 / R8: write and update channel B only
        send(4'h3, 4'h1, 16'h8001, "R5 R8 write-update B");
        // R6: sleep A with a data field that must be ignored
        send(4'h4, 4'h0, 16'hFFFF, "R6 sleep A");
        send(4'h1, 4'h0, 16'h0000, "R6 staged A untouched after sleep");
        // R10: short wake, B was running
        for (int i = 0; i < SHORT + 1; i++) idle(1, "R10 short wake");
        // R10: both down, both woken together use the long delay
        send(4'h4, 4'hF, 16'h0, "R8 sleep all");
        check("R11 both down not settled");
        send(4'h3, 4'hF, 16'hA5A5, "R10 wake both");
        for (int i = 0; i < LONG + 1; i++) idle(1, "R10 long wake");
        // R10: only A down while B down too -> long for A
        send(4'h4, 4'hF, 16'h0, "R10 sleep all again");
        send(4'h1, 4'h0, 16'h0, "R10 wake A alone from all-down");
        for (int i = 0; i < LONG + 1; i++) idle(1, "R10 long single wake");
        // R7: reserved ops, reserved select, idle op
        send(4'h2, 4'h0, 16'h5555, "R7 reserved op 2");
        send(4'h7, 4'hF, 16'h5555, "R7 reserved op 7");
        send(4'h3, 4'h2, 16'h5555, "R7 reserved select");
        send(4'hF, 4'hF, 16'h5555, "R7 idle op");
        // R9: load pin
        send(4'h0, 4'h0, 16'h1111, "R9 stage A");
        send(4'h0, 4'h1, 16'h2222, "R9 stage B");
        step(1'b0, 24'h0, 1'b1, 1'b1, "R9 pin blocked while busy");
        step(1'b1, {4'h0, 4'h0, 16'h3333}, 1'b1, 1'b0, "R9 pin ignored with valid word");
        step(1'b0, 24'h0, 1'b1, 1'b0, "R9 pin copies both");
        send(4'h4, 4'h1, 16'h0, "R9 sleep B");
        step(1'b0, 24'h0, 1'b1, 1'b0, "R9 pin wakes B");
        for (int i = 0; i < SHORT + 1; i++) idle(1, "R10 pin short wake");

        // random mix
        void'($urandom(32'd20240607));
        for (int i = 0; i < 600; i++) begin
            logic        v;
            logic [23:0] w;
            v = ($urandom % 2) == 0;
            w = {ops[$urandom % 7], sels[$urandom % 4], 16'($urandom)};
            step(v, w, ($urandom % 3) == 0, ($urandom % 3) == 0, "R2 random word");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule